// File: doc/BRIEF.md
# Break Input Qualifier

This block turns a raw external break pin into a qualified break level for a power-output stage. The pin is first mapped through a polarity selection to an "active" level. A 4-bit filter code then picks one of sixteen qualification schemes. Code 0 passes the active level straight through with no clock. Codes 1 to 15 sample the pin at either the kernel clock rate or a divided rate of a slower dead-time clock enable. The output only changes after a run of consecutive agreeing samples.

When bidirectional mode is selected and the input is armed, the block also raises an open-drain drive-low request once a qualified break is seen. This lets other devices sharing the line observe the fault. The request stays latched until software disarms the input or leaves bidirectional mode. With break disabled, the pin is ignored and the qualifier state is cleared.

Top module: `brk_qual_top`

## Requirements
- R1: With filter code 0, `brk_valid` equals `brk_en` AND the active pin level combinationally, with no clock edge needed.
- R2: The active level is `brk_pin` when `brk_pol` is 1, and the inverse of `brk_pin` when `brk_pol` is 0.
- R3: While `brk_en` is 0, `brk_valid` and `pin_drive_low` are 0 and the sample counter, prescaler and qualified level are cleared, so after re-enabling a filtered code needs a full run again.
- R4: Codes 1, 2 and 3 sample on every kernel clock edge and need runs of 2, 4 and 8 samples. An active level present from the edge after enabling appears on `brk_valid` after exactly that many edges.
- R5: Codes 4 to 15 take one sample every D-th `dts_ce` pulse, counted from enabling, with (D, N) equal to (2,6) (2,8) (4,6) (4,8) (8,6) (8,8) (16,5) (16,6) (16,8) (32,5) (32,6) (32,8) for codes 4 up to 15 in turn. With `dts_ce` held at 1, the output changes after N·D edges.
- R6: In codes 4 to 15, edges with `dts_ce` at 0 take no sample and advance nothing. In codes 1 to 3, `dts_ce` has no effect.
- R7: A sample that agrees with the current qualified level clears the run count, so a one-sample interruption restarts qualification.
- R8: Release of the break is qualified the same way as its assertion, with the same run and sampling rate.
- R9: With `brk_bidir`=1 and `brk_disarm`=0, `pin_drive_low` rises on the edge after `brk_valid` is 1. It stays 1 while the pin returns inactive, and falls on the first edge at which `brk_disarm` is 1, `brk_bidir` is 0 or `brk_en` is 0.
- R10: With `brk_bidir`=0 or `brk_disarm`=1, `pin_drive_low` stays 0 whatever the break level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| dts_ce | input | 1 | Dead-time domain clock enable, one kernel cycle wide |
| brk_pin | input | 1 | Raw break pin level |
| flt_code | input | 4 | Filter code selecting sampling rate and run length |
| brk_en | input | 1 | Break enable |
| brk_pol | input | 1 | Polarity: 1 active high, 0 active low |
| brk_disarm | input | 1 | 1 stops the block driving the pin |
| brk_bidir | input | 1 | 1 allows the block to drive the pin low |
| brk_valid | output | 1 | Qualified break level |
| pin_drive_low | output | 1 | Open-drain drive-low request for the pin |

## Verification
The hardest situation to reach is the long divided codes, where qualification takes up to 256 edges. There, the prescaler phase at the moment the pin changes decides the answer. The bench makes the phase known by pulsing `brk_en` low for one edge before every measurement, which clears the prescaler and the run counter. It then measures assertion and release latency back to back, because a release that starts right after a qualified edge begins from prescaler phase zero. The restart case comes from holding the pin active for one sample short of the run, dropping it for a single sample, and repeating.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int CODE_W = 4;
    localparam int PRE_W  = 6;
    localparam int RUN_W  = 4;

    typedef struct packed {
        logic             bypass;
        logic             use_dts;
        logic [PRE_W-1:0] div;
        logic [RUN_W-1:0] run;
    } flt_cfg_t;

    // Map a filter code to its sampling scheme.
    function automatic flt_cfg_t decode_code(input logic [CODE_W-1:0] code);
        flt_cfg_t         c;
        logic [CODE_W-1:0] idx;
        c   = '0;
        idx = '0;
        if (code == '0) begin
            c.bypass = 1'b1;
            c.div    = PRE_W'(1);
            c.run    = RUN_W'(1);
        end else if (code < CODE_W'(4)) begin
            c.div = PRE_W'(1);
            c.run = RUN_W'(RUN_W'(2) << (code - CODE_W'(1)));
        end else if (code < CODE_W'(10)) begin
            idx       = code - CODE_W'(4);
            c.use_dts = 1'b1;
            c.div     = PRE_W'(PRE_W'(2) << idx[2:1]);
            c.run     = idx[0] ? RUN_W'(8) : RUN_W'(6);
        end else begin
            idx       = code - CODE_W'(10);
            c.use_dts = 1'b1;
            c.div     = (idx < CODE_W'(3)) ? PRE_W'(16) : PRE_W'(32);
            if (idx == CODE_W'(0) || idx == CODE_W'(3))
                c.run = RUN_W'(5);
            else if (idx == CODE_W'(1) || idx == CODE_W'(4))
                c.run = RUN_W'(6);
            else
                c.run = RUN_W'(8);
        end
        return c;
    endfunction

endpackage

// File: rtl/brk_prescaler.sv
module brk_prescaler
    import brk_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         ce_i,
    input  logic         use_dts_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] pre_q;
    logic         wrap;

    assign wrap   = (pre_q >= div_i - W'(1));
    assign tick_o = use_dts_i ? (ce_i && wrap) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
        end else if (use_dts_i && ce_i) begin
            if (wrap) pre_q <= '0;
            else      pre_q <= pre_q + W'(1);
        end
    end

    // R5: on a divided rate two samples are never on adjacent edges
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        (tick_o && use_dts_i && div_i > W'(1) && !clr_i)
        |=> (!tick_o || !$stable(div_i) || !$stable(use_dts_i)));

endmodule

// File: rtl/brk_run_filter.sv
module brk_run_filter
    import brk_pkg::*;
#(
    parameter int W = RUN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         tick_i,
    input  logic         sample_i,
    input  logic [W-1:0] run_i,
    output logic         level_o
);
    logic [W-1:0] cnt_q;
    logic         level_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (tick_i) begin
            if (sample_i == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q >= run_i - W'(1)) begin
                cnt_q   <= '0;
                level_q <= sample_i;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    assign level_o = level_q;

    // R7: the qualified level moves only on a sample edge or a clear
    p_level_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_q) |-> ($past(tick_i) || $past(clr_i)));

    // R8: every level change leaves the run count empty
    p_cnt_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_q) |-> (cnt_q == '0));

endmodule

// File: rtl/brk_pin_drive.sv
module brk_pin_drive (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic bidir_i,
    input  logic disarm_i,
    input  logic brk_i,
    output logic drive_o
);
    logic drv_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i || !bidir_i || disarm_i) drv_q <= 1'b0;
        else if (brk_i)                          drv_q <= 1'b1;
    end

    assign drive_o = drv_q;

    // R10: not armed, or disabled, means no drive on the next edge
    p_drive_armed_r10: assert property (@(posedge clk) disable iff (rst)
        (!bidir_i || disarm_i || !en_i) |=> !drive_o);

    // R9: the drive request rises only after a qualified break
    p_drive_after_brk_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_o) |-> $past(brk_i));

endmodule

// File: rtl/brk_qual_top.sv
module brk_qual_top
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dts_ce,
    input  logic              brk_pin,
    input  logic [CODE_W-1:0] flt_code,
    input  logic              brk_en,
    input  logic              brk_pol,
    input  logic              brk_disarm,
    input  logic              brk_bidir,
    output logic              brk_valid,
    output logic              pin_drive_low
);
    flt_cfg_t cfg;
    logic     active;
    logic     clr;
    logic     tick;
    logic     level;

    assign cfg    = decode_code(flt_code);
    assign active = brk_pol ? brk_pin : ~brk_pin;
    assign clr    = ~brk_en;

    brk_prescaler #(.W(PRE_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr),
        .ce_i      (dts_ce),
        .use_dts_i (cfg.use_dts),
        .div_i     (cfg.div),
        .tick_o    (tick)
    );

    brk_run_filter #(.W(RUN_W)) u_run (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr | cfg.bypass),
        .tick_i   (tick),
        .sample_i (active),
        .run_i    (cfg.run),
        .level_o  (level)
    );

    assign brk_valid = brk_en & (cfg.bypass ? active : level);

    brk_pin_drive u_drv (
        .clk      (clk),
        .rst      (rst),
        .en_i     (brk_en),
        .bidir_i  (brk_bidir),
        .disarm_i (brk_disarm),
        .brk_i    (brk_valid),
        .drive_o  (pin_drive_low)
    );

    // R3: disabled break never reports a qualified level one edge later
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!brk_en && !$past(brk_en)) |-> !pin_drive_low);

endmodule

// File: tb/brk_qual_top_bench.sv
module brk_qual_top_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       dts_ce, brk_pin, brk_en, brk_pol, brk_disarm, brk_bidir;
    logic [3:0] flt_code;
    logic       brk_valid, pin_drive_low;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    brk_qual_top u_brk_qual_top (
        .clk(clk), .rst(rst), .dts_ce(dts_ce), .brk_pin(brk_pin),
        .flt_code(flt_code), .brk_en(brk_en), .brk_pol(brk_pol),
        .brk_disarm(brk_disarm), .brk_bidir(brk_bidir),
        .brk_valid(brk_valid), .pin_drive_low(pin_drive_low)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_active(input bit a);
        brk_pin = brk_pol ? a : ~a;
    endtask

    function automatic int exp_div(input int code);
        if (code < 4)  return 1;
        if (code < 10) return 2 << ((code - 4) / 2);
        if (code < 13) return 16;
        return 32;
    endfunction

    function automatic int exp_run(input int code);
        if (code < 4)  return 2 << (code - 1);
        if (code < 10) return ((code - 4) % 2) ? 8 : 6;
        case ((code - 10) % 3)
            0: return 5;
            1: return 6;
            default: return 8;
        endcase
    endfunction

    // count edges until brk_valid equals lvl (bounded)
    task automatic measure(input bit lvl, input int limit, output int k);
        k = 0;
        while (brk_valid !== lvl && k <= limit) begin
            step(1);
            k++;
        end
    endtask

    task automatic rearm();
        brk_en = 1'b0;
        set_active(1'b0);
        step(1);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int k, e;
        rst = 1'b1; dts_ce = 1'b1; brk_pol = 1'b1; brk_pin = 1'b0;
        flt_code = 4'd1; brk_en = 1'b1; brk_disarm = 1'b0; brk_bidir = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        check(brk_valid == 0, "R3 reset valid", brk_valid, 0);
        check(pin_drive_low == 0, "R9 reset drive", pin_drive_low, 0);

        // R1/R2: bypass, both polarities, no edge
        flt_code = 4'd0;
        for (int p = 0; p < 2; p++) begin
            brk_pol = p[0];
            for (int a = 0; a < 2; a++) begin
                set_active(a[0]);
                #1;
                check(brk_valid == a[0], "R1 R2 bypass", brk_valid, a);
            end
        end

        // R4/R5/R8: sweep every filtered code, both polarities
        for (int p = 0; p < 2; p++) begin
            brk_pol = p[0];
            for (int c = 1; c < 16; c++) begin
                flt_code = 4'(c);
                e = exp_div(c) * exp_run(c);
                rearm();
                brk_en = 1'b1;
                set_active(1'b1);
                measure(1'b1, e + 4, k);
                check(k == e, (c < 4) ? "R4 assert latency" : "R5 assert latency", k, e);
                set_active(1'b0);
                measure(1'b0, e + 4, k);
                check(k == e, "R8 release latency", k, e);
            end
        end

        // R6: dts_ce low freezes divided codes
        brk_pol = 1'b1;
        flt_code = 4'd4;
        rearm();
        brk_en = 1'b1; dts_ce = 1'b0; set_active(1'b1);
        step(40);
        check(brk_valid == 0, "R6 frozen", brk_valid, 0);
        dts_ce = 1'b1;
        measure(1'b1, 20, k);
        check(k == 12, "R6 resume latency", k, 12);
        // R6: kernel-rate code ignores dts_ce
        flt_code = 4'd2;
        rearm();
        brk_en = 1'b1; dts_ce = 1'b0; set_active(1'b1);
        measure(1'b1, 10, k);
        check(k == 4, "R6 kernel rate ignores ce", k, 4);
        dts_ce = 1'b1;

        // R7: one-sample interruption restarts the run
        flt_code = 4'd3;
        rearm();
        brk_en = 1'b1;
        set_active(1'b1); step(7);
        set_active(1'b0); step(1);
        set_active(1'b1); step(7);
        check(brk_valid == 0, "R7 restart", brk_valid, 0);
        step(1);
        check(brk_valid == 1, "R7 completes", brk_valid, 1);

        // R3: disabled ignores pin, re-enable needs full run
        flt_code = 4'd1;
        brk_en = 1'b0; step(10);
        check(brk_valid == 0, "R3 disabled filtered", brk_valid, 0);
        flt_code = 4'd0; #1;
        check(brk_valid == 0, "R3 disabled bypass", brk_valid, 0);
        flt_code = 4'd1;
        brk_en = 1'b1; step(1);
        check(brk_valid == 0, "R3 cleared state", brk_valid, 0);
        step(1);
        check(brk_valid == 1, "R3 full run after enable", brk_valid, 1);

        // R9: armed bidirectional drive, active low pin
        brk_pol = 1'b0;
        rearm();
        brk_en = 1'b1; brk_bidir = 1'b1; brk_disarm = 1'b0;
        set_active(1'b1);
        step(2);
        check(brk_valid == 1 && pin_drive_low == 0, "R9 drive one edge late", pin_drive_low, 0);
        step(1);
        check(pin_drive_low == 1, "R9 drive set", pin_drive_low, 1);
        set_active(1'b0); step(3);
        check(brk_valid == 0 && pin_drive_low == 1, "R9 drive latched", pin_drive_low, 1);
        brk_disarm = 1'b1; step(1);
        check(pin_drive_low == 0, "R9 disarm clears", pin_drive_low, 0);

        // R10: disarmed or input-only never drives
        set_active(1'b1); step(5);
        check(brk_valid == 1 && pin_drive_low == 0, "R10 disarmed", pin_drive_low, 0);
        brk_disarm = 1'b0; brk_bidir = 1'b0; step(5);
        check(brk_valid == 1 && pin_drive_low == 0, "R10 input only", pin_drive_low, 0);
        brk_bidir = 1'b1; step(1);
        check(pin_drive_low == 1, "R9 rearm drives", pin_drive_low, 1);
        brk_bidir = 1'b0; step(1);
        check(pin_drive_low == 0, "R9 bidir low clears", pin_drive_low, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule